// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block turns bus addresses into eight chip-select outputs for external memories and peripherals. Software programs each channel through a small write-only register port. Each channel has a base address, a don't-care mask, a control word and a port width that the bus controller uses. The control word holds a valid bit, the port width, a wait-state count, a termination choice and four permission inhibits.

When `acc_start_i` is sampled high and the unit is idle, the address and access type are compared against every channel at once. The lowest-numbered channel that is enabled, matches and allows the access type is selected. Its select is held while that channel's wait states elapse. The access then ends with a one-cycle internal acknowledge, or when the external acknowledge arrives.

After reset, channel 0 acts as a global boot select that answers every address. This lasts until software writes a control word to channel 0 with its valid bit set. If no channel claims an access, no select is driven and a one-cycle no-match flag is raised for the bus monitor.

Top module: `cs_unit`

## Requirements
- R1: After reset `cs_o`, `ack_o`, `no_match_o` and `width_o` are all zero.
- R2: Until a control write to channel 0 has bit 0 (valid) set, channel 0 claims every address and every access type. It uses width code 2, 7 wait states and internal termination. Writes to channel 0 base or mask alone do not end this mode.
- R3: A valid channel matches when `(addr ^ base) & ~mask` is zero, so a mask bit of 1 means "don't care". Register codes on `cfg_reg_i` are 0 for base, 1 for mask and 2 for control.
- R4: When several channels claim an access, only the lowest-numbered one is selected.
- R5: Control bits 8, 9, 10 and 11 inhibit reads, writes, supervisor accesses and user accesses. An inhibited channel does not assert its select, and a lower-priority channel may claim the access instead.
- R6: The wait count is N (control bits 6:3). With internal termination, the select is high for N+1 cycles starting the cycle after the start is sampled. `ack_o` is high only in the last of these cycles, and the select drops after it.
- R7: With control bit 7 set, `ack_o` stays low. The select is held until `ext_ack_i` is sampled high after the wait count has reached zero. An `ext_ack_i` seen earlier is ignored.
- R8: `width_o` shows the selected channel's width code (control bits 2:1; 0 = 8-bit, 1 = 16-bit, 2 = 32-bit) while a select is high, and it is zero when idle.
- R9: An access that no channel claims drives no select. It raises `no_match_o` for exactly one cycle, the cycle after the start.
- R10: `acc_start_i` is ignored while an access is in progress; the active select and its timing are unchanged.
- R11: A channel with its valid bit clear is never selected, even when its base and mask match.
- R12: At most one bit of `cs_o` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 3 | Channel addressed by the write |
| cfg_reg_i | input | 2 | Register code: 0 base, 1 mask, 2 control |
| cfg_wdata_i | input | 32 | Write data |
| acc_start_i | input | 1 | Start of a bus access (one cycle) |
| acc_addr_i | input | 32 | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_super_i | input | 1 | 1 = supervisor, 0 = user |
| ext_ack_i | input | 1 | External transfer acknowledge |
| cs_o | output | 8 | Chip selects, active high, one per channel |
| width_o | output | 2 | Port width code of the active channel |
| ack_o | output | 1 | Internal transfer acknowledge |
| no_match_o | output | 1 | Access was claimed by no channel |

## Verification
Errors in the stored configuration show up on the first access that reaches the affected channel. A wrong base, mask, permission or valid bit sends the select to another line or raises `no_match_o` one cycle after the start. A corrupted wait counter or termination flag moves `ack_o` and the falling edge of the select to another cycle within that same access. It can also hold the select until an external acknowledge comes. A boot flag that clears too early or too late appears on the first access after reset or after the first control write to channel 0. Random configurations with overlapping regions, together with directed boot, early-acknowledge and restart cases, reach each of these paths.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned WAIT_W = 4;

  typedef enum logic [1:0] {PW_8 = 2'd0, PW_16 = 2'd1, PW_32 = 2'd2} port_w_e;
  typedef enum logic [1:0] {REG_BASE = 2'd0, REG_MASK = 2'd1, REG_CTRL = 2'd2} reg_sel_e;

  // bit 0 valid, 2:1 width, 6:3 wait, 7 ext term, 8..11 inhibit rd/wr/sup/usr
  typedef struct packed {
    logic              no_user;
    logic              no_super;
    logic              no_write;
    logic              no_read;
    logic              ext_term;
    logic [WAIT_W-1:0] wait_n;
    logic [1:0]        width;
    logic              valid;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic perm_ok(ctrl_t c, logic wr, logic sup);
    return !(wr ? c.no_write : c.no_read) && !(sup ? c.no_super : c.no_user);
  endfunction
endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS    = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BOOT_WAIT = 7,
  localparam int unsigned CH_W     = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_reg_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] base_o [NUM_CS],
  output logic [ADDR_W-1:0] mask_o [NUM_CS],
  output ctrl_t             ctrl_o [NUM_CS]
);
  localparam ctrl_t BOOT_CTRL = '{no_user: 1'b0, no_super: 1'b0, no_write: 1'b0,
                                  no_read: 1'b0, ext_term: 1'b0,
                                  wait_n: WAIT_W'(BOOT_WAIT), width: PW_32, valid: 1'b1};

  logic boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else if (cfg_we_i && cfg_ch_i == '0 && cfg_reg_i == REG_CTRL && cfg_wdata_i[0])
      boot_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ch
    logic [ADDR_W-1:0] base_q, mask_q;
    ctrl_t             ctrl_q;
    logic              wr_sel;

    assign wr_sel = cfg_we_i && (cfg_ch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        mask_q <= '0;
        ctrl_q <= '0;
      end else if (wr_sel) begin
        case (cfg_reg_i)
          REG_BASE: base_q <= cfg_wdata_i;
          REG_MASK: mask_q <= cfg_wdata_i;
          REG_CTRL: ctrl_q <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
          default:  ;
        endcase
      end
    end

    if (g == 0) begin : g_boot
      assign base_o[g] = base_q;
      assign mask_o[g] = boot_q ? '1 : mask_q;
      assign ctrl_o[g] = boot_q ? BOOT_CTRL : ctrl_q;
    end else begin : g_norm
      assign base_o[g] = base_q;
      assign mask_o[g] = mask_q;
      assign ctrl_o[g] = ctrl_q;
    end
  end
endmodule

// File: rtl/cs_match.sv
module cs_match #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CH_W  = $clog2(NUM_CS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i [NUM_CS],
  input  logic [ADDR_W-1:0] mask_i [NUM_CS],
  input  logic [NUM_CS-1:0] en_i,
  output logic              hit_o,
  output logic [CH_W-1:0]   idx_o
);
  logic [NUM_CS-1:0] hit_v;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign hit_v[g] = en_i[g] && (((addr_i ^ base_i[g]) & ~mask_i[g]) == '0);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (hit_v[i]) idx_o = CH_W'(i);
  end

  assign hit_o = |hit_v;
endmodule

// File: rtl/cs_term.sv
module cs_term
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hit_i,
  input  logic [CH_W-1:0]   idx_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [1:0]        width_i,
  input  logic              ext_i,
  input  logic              ext_ack_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic [1:0]        width_o,
  output logic              ack_o,
  output logic              no_match_o
);
  logic              active_q, ext_q, nomatch_q;
  logic [NUM_CS-1:0] sel_q;
  logic [1:0]        width_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              take, done;

  assign take = start_i && !active_q;
  assign done = active_q && (cnt_q == '0) && (!ext_q || ext_ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      ext_q     <= 1'b0;
      nomatch_q <= 1'b0;
      sel_q     <= '0;
      width_q   <= '0;
      cnt_q     <= '0;
    end else begin
      nomatch_q <= take && !hit_i;
      if (take && hit_i) begin
        active_q <= 1'b1;
        sel_q    <= NUM_CS'(1) << idx_i;
        width_q  <= width_i;
        cnt_q    <= wait_i;
        ext_q    <= ext_i;
      end else if (active_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (done) begin
        active_q <= 1'b0;
        sel_q    <= '0;
        width_q  <= '0;
      end
    end
  end

  assign cs_o       = sel_q;
  assign width_o    = width_q;
  assign ack_o      = active_q && (cnt_q == '0) && !ext_q;
  assign no_match_o = nomatch_q;
endmodule

// File: rtl/cs_unit.sv
module cs_unit
  import cs_pkg::*;
#(
  parameter int unsigned NUM_CS    = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BOOT_WAIT = 7,
  localparam int unsigned CH_W     = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [1:0]        cfg_reg_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              acc_start_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_super_i,
  input  logic              ext_ack_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic [1:0]        width_o,
  output logic              ack_o,
  output logic              no_match_o
);
  logic [ADDR_W-1:0] base [NUM_CS];
  logic [ADDR_W-1:0] mask [NUM_CS];
  ctrl_t             ctrl [NUM_CS];
  logic [NUM_CS-1:0] en;
  logic              hit;
  logic [CH_W-1:0]   win_idx;
  ctrl_t             win_c;

  cs_cfg_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BOOT_WAIT(BOOT_WAIT)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_ch_i, .cfg_reg_i, .cfg_wdata_i,
    .base_o(base), .mask_o(mask), .ctrl_o(ctrl)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_en
    assign en[g] = ctrl[g].valid && perm_ok(ctrl[g], acc_write_i, acc_super_i);
  end

  cs_match #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_match (
    .addr_i(acc_addr_i), .base_i(base), .mask_i(mask), .en_i(en),
    .hit_o(hit), .idx_o(win_idx)
  );

  assign win_c = ctrl[win_idx];

  cs_term #(.NUM_CS(NUM_CS)) u_term (
    .clk_i, .rst_ni,
    .start_i(acc_start_i), .hit_i(hit), .idx_i(win_idx),
    .wait_i(win_c.wait_n), .width_i(win_c.width), .ext_i(win_c.ext_term),
    .ext_ack_i, .cs_o, .width_o, .ack_o, .no_match_o
  );
endmodule

// File: rtl/cs_unit_chk.sv
module cs_unit_chk #(
  parameter int unsigned NUM_CS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] cs_o,
  input logic [1:0]        width_o,
  input logic              ack_o,
  input logic              no_match_o,
  input logic              ext_ack_i
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R12
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R6
  AST_ACK_ENDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> cs_o == '0); // R6
  AST_ACK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> cs_o != '0); // R6
  AST_NOMATCH_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_match_o |-> cs_o == '0); // R9
  AST_WIDTH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o == '0) |-> (width_o == 2'd0)); // R8
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0 && !ack_o && !ext_ack_i) |=> $stable(cs_o) && $stable(width_o)); // R10
endmodule

bind cs_unit cs_unit_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_o(cs_o), .width_o(width_o),
  .ack_o(ack_o), .no_match_o(no_match_o), .ext_ack_i(ext_ack_i)
);

// File: tb/cs_unit_tb.sv
`timescale 1ns/1ps
module cs_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_ch = 0;
  logic [1:0]  cfg_reg = 0;
  logic [31:0] cfg_wdata = 0;
  logic        acc_start = 0, acc_write = 0, acc_super = 0, ext_ack = 0;
  logic [31:0] acc_addr = 0;
  logic [7:0]  cs;
  logic [1:0]  width;
  logic        ack, no_match;

  int total = 0, bad = 0;

  logic [31:0] m_base [8];
  logic [31:0] m_mask [8];
  logic [11:0] m_ctrl [8];
  bit          m_boot;

  always #10 clk = ~clk;

  cs_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata), .acc_start_i(acc_start),
    .acc_addr_i(acc_addr), .acc_write_i(acc_write), .acc_super_i(acc_super),
    .ext_ack_i(ext_ack), .cs_o(cs), .width_o(width), .ack_o(ack),
    .no_match_o(no_match)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] mk_ctrl(bit v, logic [1:0] w, logic [3:0] n, bit ext,
                                          bit nr, bit nw, bit ns, bit nu);
    return {nu, ns, nw, nr, ext, n, w, v};
  endfunction

  function automatic logic [11:0] eff_ctrl(int ch);
    if (ch == 0 && m_boot) return mk_ctrl(1, 2'd2, 4'd7, 0, 0, 0, 0, 0);
    return m_ctrl[ch];
  endfunction

  function automatic int exp_ch(logic [31:0] a, bit wr, bit sup);
    for (int i = 0; i < 8; i++) begin
      logic [11:0] c;
      logic [31:0] mk;
      c  = eff_ctrl(i);
      mk = (i == 0 && m_boot) ? 32'hFFFF_FFFF : m_mask[i];
      if (c[0] && (((a ^ m_base[i]) & ~mk) == 0) &&
          !(wr ? c[9] : c[8]) && !(sup ? c[10] : c[11]))
        return i;
    end
    return -1;
  endfunction

  task automatic cfg_wr(input int ch, input int r, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_reg = 2'(r); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (r)
      0: m_base[ch] = d;
      1: m_mask[ch] = d;
      2: begin m_ctrl[ch] = d[11:0]; if (ch == 0 && d[0]) m_boot = 0; end
      default: ;
    endcase
  endtask

  task automatic do_acc(input logic [31:0] a, input bit wr, input bit sup,
                        input bit glitch, input int xdly, input string req);
    int ch, w;
    bit ext;
    logic [11:0] c;
    logic [7:0] oh;
    ch = exp_ch(a, wr, sup);
    @(negedge clk);
    acc_addr = a; acc_write = wr; acc_super = sup; acc_start = 1;
    @(negedge clk);
    acc_start = 0;
    if (ch < 0) begin
      chk(no_match == 1'b1 && cs == 0, {req, "/R9"}, {23'd0, cs, no_match}, 32'd1);
      @(negedge clk);
      chk(no_match == 1'b0 && cs == 0, "R9", {23'd0, cs, no_match}, 32'd0);
      return;
    end
    c = eff_ctrl(ch); w = int'(c[6:3]); ext = c[7];
    oh = 8'd1 << ch;
    for (int k = 0; k <= w; k++) begin
      chk(cs == oh, req, 32'(cs), 32'(oh));
      chk(width == c[2:1], "R8", 32'(width), 32'(c[2:1]));
      chk(ack == (k == w && !ext), ext ? "R7" : "R6", 32'(ack), 32'(k == w && !ext));
      acc_start = (glitch && k == 0 && w > 0);
      if (acc_start) acc_addr = ~a;      // R10 restart attempt
      ext_ack = (ext && k < w);          // R7 early acknowledge
      if (k < w) @(negedge clk);
    end
    acc_start = 0;
    ext_ack = 0;
    if (ext) begin
      for (int d = 0; d < xdly; d++) begin
        @(negedge clk);
        chk(cs == oh && ack == 0, "R7", {23'd0, cs, ack}, {23'd0, oh, 1'b0});
      end
      ext_ack = 1;
      @(negedge clk);
      ext_ack = 0;
    end else begin
      @(negedge clk);
    end
    chk(cs == 0 && width == 0, ext ? "R7" : "R6", {22'd0, cs, width}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_mask[i] = 0; m_ctrl[i] = 0; end
    m_boot = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs == 0 && ack == 0 && no_match == 0 && width == 0, "R1",
        {21'd0, cs, width, ack, no_match}, 32'd0);

    // boot select, every type
    do_acc(32'h1234_5678, 0, 1, 0, 0, "R2");
    do_acc(32'hFFFF_FFF0, 1, 0, 0, 0, "R2");
    cfg_wr(0, 0, 32'h4000_0000);
    cfg_wr(0, 1, 32'h0000_FFFF);
    cfg_wr(0, 2, mk_ctrl(0, 2'd0, 4'd1, 0, 0, 0, 0, 0));   // valid clear: boot stays
    do_acc(32'h8000_0004, 0, 0, 0, 0, "R2");
    do_acc(32'h0000_0000, 1, 1, 1, 0, "R10");

    // leave boot
    cfg_wr(0, 2, mk_ctrl(1, 2'd1, 4'd2, 0, 0, 0, 0, 0));
    do_acc(32'h4000_1234, 0, 0, 0, 0, "R3");
    do_acc(32'h4001_1234, 0, 0, 0, 0, "R3");       // outside mask -> no match
    cfg_wr(1, 0, 32'h8000_0000);
    cfg_wr(1, 1, 32'h0FFF_FFFF);
    cfg_wr(1, 2, mk_ctrl(0, 2'd2, 4'd0, 0, 0, 0, 0, 0));
    do_acc(32'h8000_0010, 0, 1, 0, 0, "R11");

    // overlap + permissions
    cfg_wr(2, 0, 32'hA000_0000); cfg_wr(2, 1, 32'h00FF_FFFF);
    cfg_wr(2, 2, mk_ctrl(1, 2'd0, 4'd3, 0, 0, 1, 0, 0));
    cfg_wr(5, 0, 32'hA000_0000); cfg_wr(5, 1, 32'h0FFF_FFFF);
    cfg_wr(5, 2, mk_ctrl(1, 2'd2, 4'd1, 0, 0, 0, 0, 1));
    do_acc(32'hA000_0100, 0, 0, 0, 0, "R4");
    do_acc(32'hA000_0100, 1, 1, 0, 0, "R5");
    do_acc(32'hA000_0100, 1, 0, 0, 0, "R5");
    do_acc(32'hA100_0000, 0, 0, 0, 0, "R5");

    // external termination with early acks
    cfg_wr(3, 0, 32'hC000_0000); cfg_wr(3, 1, 32'h000F_FFFF);
    cfg_wr(3, 2, mk_ctrl(1, 2'd1, 4'd4, 1, 0, 0, 0, 0));
    do_acc(32'hC000_0040, 1, 1, 0, 3, "R7");
    do_acc(32'hC000_0040, 0, 0, 1, 0, "R10");

    // random phase
    for (int blk = 0; blk < 10; blk++) begin
      for (int ch = 0; ch < 8; ch++) begin
        logic [31:0] mk;
        case ($urandom_range(0, 2))
          0: mk = 32'h0FFF_FFFF;
          1: mk = 32'h1FFF_FFFF;
          default: mk = 32'h3FFF_FFFF;
        endcase
        cfg_wr(ch, 0, {3'($urandom_range(0, 7)), 29'd0});
        cfg_wr(ch, 1, mk);
        cfg_wr(ch, 2, mk_ctrl($urandom_range(0, 3) != 0, 2'($urandom_range(0, 2)),
                              ($urandom_range(0, 7) == 0) ? 4'd15 : 4'($urandom_range(0, 5)),
                              $urandom_range(0, 3) == 0,
                              $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                              $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0));
      end
      for (int n = 0; n < 25; n++)
        do_acc($urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 4) == 0, $urandom_range(0, 3), "R3/R4/R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule